// File: doc/BRIEF.md
# D-PHY Lane Timing Sequencer

This block steers the low-power to high-speed transitions of one clock lane and up to four data lanes of a D-PHY style transmitter. Everything runs on the byte clock. Each interval comes from an 8-bit field, and a field value of N holds its state for exactly N cycles. The block reports each lane's line state as a 3-bit code. An analog front end and a serialiser downstream turn those codes into line levels.

A burst starts when `burst_start` pulses with the global enable set. The clock lane starts high-speed clocking first. The data lanes follow once the clock has run for its pre interval. While the data lanes are in HS-data and no end has been requested, `hs_ready` is high. A payload beat moves when the sender's valid and `hs_ready` are both high, so the only back-pressure is `hs_ready` going low. A pulse on `burst_end` closes the burst. In continuous-clock mode the clock lane stays in high-speed clocking between bursts.

Top module: `dphy_lane_seq`

## Requirements
- R1: After reset every lane reports LP-11 and `hs_ready` is low.
- R2: State codes are 0 LP-11, 1 LP-01, 2 LP-00, 3 HS-zero, 4 HS-data (on the clock lane, HS clocking) and 5 HS-trail. The clock lane moves LP-11 → LP-01 (low-power divider) → LP-00 (clock prepare) → HS-zero (clock zero) → HS clocking when the enable is set and a burst is pending or continuous mode is on.
- R3: Data lanes leave LP-11 only once the clock lane has been in HS clocking for the clock-pre count. The first data LP-01 cycle comes clock-pre + 1 cycles after the first HS clocking cycle.
- R4: Active data lanes move LP-01 (low-power divider) → LP-00 (data prepare) → HS-zero (DATA_ZERO_CYCLES) → HS-data. On an end request they move to HS-trail for the data-trail count and then back to LP-11.
- R5: Outside continuous mode, the clock lane stays in HS clocking for exactly clock-post cycles, counted from the first cycle in which the data lanes show LP-11 with no burst pending. It then holds HS-trail for clock-trail cycles and returns to LP-11. A new start during that wait cancels the exit.
- R6: With continuous mode and enable both set, the clock lane never leaves HS clocking.
- R7: The lane count is (ctrl bits 5:4) + 1 and is captured when the data lanes leave LP-11. Lanes at or above the count report LP-11 throughout.
- R8: An interval field of 0 behaves as 1, and a field of N holds its state for exactly N cycles.
- R9: While ctrl bit 0 (enable) is low, no lane leaves LP-11 and `burst_start` pulses are dropped, not remembered.
- R10: `hs_ready` is high exactly when the data lanes are in HS-data and no end request is held.
- R11: Field positions: data word [31:24] data trail, [23:16] data prepare, [7:0] low-power divider. Clock word [31:24] post, [23:16] pre, [15:8] zero, [7:0] prepare. Trail word [7:0] clock trail.
- R12: An end request that arrives in LP-01, LP-00 or HS-zero is held. The lanes then spend one HS-data cycle with `hs_ready` low and go on to HS-trail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Bit 0 enable, bits 5:4 lane count minus one |
| data_time_word | input | 32 | Data trail, data prepare, low-power divider |
| clk_time_word | input | 32 | Clock post, pre, zero, prepare |
| clk_trail_word | input | 32 | Clock trail in bits 7:0 |
| clk_cont | input | 1 | Continuous high-speed clock mode |
| burst_start | input | 1 | One-cycle request to begin a burst |
| burst_end | input | 1 | One-cycle request to end the burst |
| clk_lane_st | output | 3 | Clock lane state code |
| data_lane_st | output | 12 | Data lane state codes, lane i in bits 3i+2:3i |
| hs_ready | output | 1 | Data lanes accept payload |

## Verification
The hardest case to reach is a new start that lands inside the clock-post wait. It has to arrive after the data lanes are back in LP-11 but before the post count runs out, so the clock lane keeps clocking and the data lanes leave again at once. The stimulus waits at the ports for data LP-11 with the clock still in HS clocking, then pulses `burst_start` a few cycles later with a long post field. An end request inside LP-00 and a continuous-mode to normal-mode switch are driven the same way, by watching the lane codes.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

  typedef enum logic [2:0] {
    LS_STOP    = 3'd0,
    LS_REQ     = 3'd1,
    LS_BRIDGE  = 3'd2,
    LS_HSZERO  = 3'd3,
    LS_HSRUN   = 3'd4,
    LS_HSTRAIL = 3'd5
  } lane_st_e;

  typedef struct packed {
    logic [7:0] lp_div;
    logic [7:0] dat_prep;
    logic [7:0] dat_trail;
    logic [7:0] clk_prep;
    logic [7:0] clk_zero;
    logic [7:0] clk_pre;
    logic [7:0] clk_post;
    logic [7:0] clk_trail;
  } seq_times_t;

  function automatic logic [7:0] at_least_one(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

endpackage

// File: rtl/dphy_seq_fields.sv
module dphy_seq_fields
  import dphy_seq_pkg::*;
(
  input  logic [31:0] ctrl_word,
  input  logic [31:0] data_time_word,
  input  logic [31:0] clk_time_word,
  input  logic [31:0] clk_trail_word,
  output seq_times_t  times,
  output logic        enable,
  output logic [1:0]  lane_field
);

  // Field positions are fixed by R11 and the control word layout
  assign enable          = ctrl_word[0];
  assign lane_field      = ctrl_word[5:4];
  assign times.dat_trail = data_time_word[31:24];
  assign times.dat_prep  = data_time_word[23:16];
  assign times.lp_div    = data_time_word[7:0];
  assign times.clk_post  = clk_time_word[31:24];
  assign times.clk_pre   = clk_time_word[23:16];
  assign times.clk_zero  = clk_time_word[15:8];
  assign times.clk_prep  = clk_time_word[7:0];
  assign times.clk_trail = clk_trail_word[7:0];

  logic unused_bits;
  assign unused_bits = ^{ctrl_word[31:6], ctrl_word[3:1],
                         data_time_word[15:8], clk_trail_word[31:8]};

endmodule

// File: rtl/dphy_clk_lane.sv
module dphy_clk_lane
  import dphy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cont_mode,
  input  logic       burst_pend,
  input  logic       data_idle,
  input  seq_times_t times,
  output lane_st_e   st_o,
  output logic       pre_done_o
);

  lane_st_e   st_q;
  logic [7:0] cnt_q;
  logic [7:0] post_q;
  logic       pre_q;
  logic       cont_on;
  logic       leave_ok;

  assign cont_on  = cont_mode & enable;
  assign leave_ok = pre_q & ~burst_pend & data_idle & ~cont_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_STOP;
      cnt_q  <= 8'd0;
      post_q <= 8'd0;
      pre_q  <= 1'b0;
    end else begin
      case (st_q)
        LS_STOP: begin
          if (enable && (burst_pend || cont_mode)) begin
            st_q  <= LS_REQ;
            cnt_q <= at_least_one(times.lp_div) - 8'd1;
          end
        end
        LS_REQ: begin
          if (cnt_q == 8'd0) begin
            st_q  <= LS_BRIDGE;
            cnt_q <= at_least_one(times.clk_prep) - 8'd1;
          end else begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        LS_BRIDGE: begin
          if (cnt_q == 8'd0) begin
            st_q  <= LS_HSZERO;
            cnt_q <= at_least_one(times.clk_zero) - 8'd1;
          end else begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        LS_HSZERO: begin
          if (cnt_q == 8'd0) begin
            st_q   <= LS_HSRUN;
            cnt_q  <= at_least_one(times.clk_pre) - 8'd1;
            pre_q  <= 1'b0;
            post_q <= 8'd0;
          end else begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        LS_HSRUN: begin
          if (!pre_q) begin
            if (cnt_q == 8'd0) pre_q <= 1'b1;
            else               cnt_q <= cnt_q - 8'd1;
          end
          if (leave_ok) begin
            if (post_q == at_least_one(times.clk_post) - 8'd1) begin
              st_q   <= LS_HSTRAIL;
              cnt_q  <= at_least_one(times.clk_trail) - 8'd1;
              pre_q  <= 1'b0;
              post_q <= 8'd0;
            end else begin
              post_q <= post_q + 8'd1;
            end
          end else begin
            post_q <= 8'd0;
          end
        end
        LS_HSTRAIL: begin
          if (cnt_q == 8'd0) st_q <= LS_STOP;
          else               cnt_q <= cnt_q - 8'd1;
        end
        default: st_q <= LS_STOP;
      endcase
    end
  end

  assign st_o       = st_q;
  assign pre_done_o = pre_q;

  AST_CLK_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_STOP && !enable) |=> (st_q == LS_STOP)); // R9

  AST_CLK_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_on && st_q == LS_HSRUN) |=> (st_q == LS_HSRUN)); // R6

  AST_CLK_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q <= LS_HSTRAIL)); // R2

endmodule

// File: rtl/dphy_data_lanes.sv
module dphy_data_lanes
  import dphy_seq_pkg::*;
#(
  parameter int DATA_ZERO_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       burst_start,
  input  logic       burst_end,
  input  logic       clk_pre_done,
  input  logic [1:0] lane_field,
  input  seq_times_t times,
  output lane_st_e   st_o,
  output logic       pend_o,
  output logic       ready_o,
  output logic [1:0] act_o
);

  localparam logic [7:0] ZERO_LOAD = 8'(DATA_ZERO_CYCLES - 1);

  lane_st_e   st_q;
  logic [7:0] cnt_q;
  logic       pend_q;
  logic       end_q;
  logic [1:0] act_q;
  logic       early_phase;

  assign early_phase = (st_q == LS_REQ) || (st_q == LS_BRIDGE) || (st_q == LS_HSZERO);

  // Pending start: a new request wins over the clear on departure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pend_q <= 1'b0;
    else if (burst_start && enable)               pend_q <= 1'b1;
    else if (st_q == LS_STOP && clk_pre_done)     pend_q <= 1'b0;
  end

  // End request held until HS-data is reached
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          end_q <= 1'b0;
    else if (st_q == LS_HSRUN)           end_q <= 1'b0;
    else if (burst_end && early_phase)   end_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_STOP;
      cnt_q <= 8'd0;
      act_q <= 2'd0;
    end else begin
      case (st_q)
        LS_STOP: begin
          if (pend_q && clk_pre_done) begin
            st_q  <= LS_REQ;
            cnt_q <= at_least_one(times.lp_div) - 8'd1;
            act_q <= lane_field;
          end
        end
        LS_REQ: begin
          if (cnt_q == 8'd0) begin
            st_q  <= LS_BRIDGE;
            cnt_q <= at_least_one(times.dat_prep) - 8'd1;
          end else begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        LS_BRIDGE: begin
          if (cnt_q == 8'd0) begin
            st_q  <= LS_HSZERO;
            cnt_q <= ZERO_LOAD;
          end else begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        LS_HSZERO: begin
          if (cnt_q == 8'd0) st_q <= LS_HSRUN;
          else               cnt_q <= cnt_q - 8'd1;
        end
        LS_HSRUN: begin
          if (end_q || burst_end) begin
            st_q  <= LS_HSTRAIL;
            cnt_q <= at_least_one(times.dat_trail) - 8'd1;
          end
        end
        LS_HSTRAIL: begin
          if (cnt_q == 8'd0) st_q <= LS_STOP;
          else               cnt_q <= cnt_q - 8'd1;
        end
        default: st_q <= LS_STOP;
      endcase
    end
  end

  assign st_o    = st_q;
  assign pend_o  = pend_q;
  assign act_o   = act_q;
  assign ready_o = (st_q == LS_HSRUN) && !end_q;

  AST_DATA_WAITS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_STOP) |=> (st_q != LS_REQ || $past(clk_pre_done))); // R3

  AST_TRAIL_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_HSTRAIL) |-> ($past(st_q) == LS_HSRUN || $past(st_q) == LS_HSTRAIL)); // R4

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
  import dphy_seq_pkg::*;
#(
  parameter int NUM_LANES        = 4,
  parameter int DATA_ZERO_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [31:0]                ctrl_word,
  input  logic [31:0]                data_time_word,
  input  logic [31:0]                clk_time_word,
  input  logic [31:0]                clk_trail_word,
  input  logic                       clk_cont,
  input  logic                       burst_start,
  input  logic                       burst_end,
  output logic [2:0]                 clk_lane_st,
  output logic [NUM_LANES*3-1:0]     data_lane_st,
  output logic                       hs_ready
);

  localparam int ST_W = 3;

  seq_times_t times;
  logic       enable;
  logic [1:0] lane_field;
  lane_st_e   clk_st;
  lane_st_e   dat_st;
  logic       pre_done;
  logic       pend;
  logic [1:0] act;

  dphy_seq_fields u_fields (
    .ctrl_word      (ctrl_word),
    .data_time_word (data_time_word),
    .clk_time_word  (clk_time_word),
    .clk_trail_word (clk_trail_word),
    .times          (times),
    .enable         (enable),
    .lane_field     (lane_field)
  );

  dphy_clk_lane u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cont_mode  (clk_cont),
    .burst_pend (pend),
    .data_idle  (dat_st == LS_STOP),
    .times      (times),
    .st_o       (clk_st),
    .pre_done_o (pre_done)
  );

  dphy_data_lanes #(.DATA_ZERO_CYCLES(DATA_ZERO_CYCLES)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .burst_start  (burst_start),
    .burst_end    (burst_end),
    .clk_pre_done (pre_done),
    .lane_field   (lane_field),
    .times        (times),
    .st_o         (dat_st),
    .pend_o       (pend),
    .ready_o      (hs_ready),
    .act_o        (act)
  );

  assign clk_lane_st = clk_st;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam logic [1:0] IDX = 2'(i);
    assign data_lane_st[i*ST_W +: ST_W] = (IDX <= act) ? dat_st : LS_STOP;
  end

  AST_CLK_HS_DURING_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_st != LS_STOP) |-> (clk_st == LS_HSRUN)); // R5

  AST_READY_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ready |-> (clk_st == LS_HSRUN)); // R10

endmodule

// File: tb/test_dphy_lane_seq.sv
`timescale 1ns/1ps
module test_dphy_lane_seq;

  localparam int NL = 4;
  localparam int DZ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_w = 32'd0, data_w = 32'd0, clkt_w = 32'd0, trail_w = 32'd0;
  logic        cont = 1'b0, bs = 1'b0, be = 1'b0;
  logic [2:0]  clk_st;
  logic [NL*3-1:0] dat_st;
  logic        ready;

  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  dphy_lane_seq #(.NUM_LANES(NL), .DATA_ZERO_CYCLES(DZ)) i_dphy_lane_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_w), .data_time_word(data_w),
    .clk_time_word(clkt_w), .clk_trail_word(trail_w), .clk_cont(cont),
    .burst_start(bs), .burst_end(be), .clk_lane_st(clk_st),
    .data_lane_st(dat_st), .hs_ready(ready));

  function automatic int e(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Reference model, behavioural, fields decoded per R11
  int m_c, m_cl, m_pl, m_post, m_d, m_dl, m_act;
  bit m_pre, m_pend, m_endp;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = 0; m_cl = 0; m_pl = 0; m_post = 0; m_d = 0; m_dl = 0; m_act = 0;
      m_pre = 0; m_pend = 0; m_endp = 0;
    end else begin
      int lp, dp, dt, cp, cz, cpr, cpo, ctr, ln;
      int nc, ncl, npl, npost, nd, ndl, nact;
      bit en, npre, npend, nendp, cond;
      lp = int'(data_w & 255); dp = int'((data_w >> 16) & 255); dt = int'(data_w >> 24);
      cp = int'(clkt_w & 255); cz = int'((clkt_w >> 8) & 255);
      cpr = int'((clkt_w >> 16) & 255); cpo = int'(clkt_w >> 24); ctr = int'(trail_w & 255);
      en = ctrl_w[0]; ln = int'(ctrl_w[5:4]);
      nc = m_c; ncl = m_cl - 1; npl = m_pl; npost = m_post; npre = m_pre;
      nd = m_d; ndl = m_dl - 1; nact = m_act; npend = m_pend; nendp = m_endp;
      if (m_c == 0) begin
        ncl = m_cl;
        if (en && (m_pend || cont)) begin nc = 1; ncl = e(lp); end
      end else if (m_c == 1) begin
        if (m_cl == 1) begin nc = 2; ncl = e(cp); end
      end else if (m_c == 2) begin
        if (m_cl == 1) begin nc = 3; ncl = e(cz); end
      end else if (m_c == 3) begin
        if (m_cl == 1) begin nc = 4; npl = e(cpr); npre = 0; npost = 0; end
      end else if (m_c == 4) begin
        ncl = m_cl;
        cond = m_pre && !m_pend && m_d == 0 && !(cont && en);
        if (!m_pre) begin npl = m_pl - 1; if (npl == 0) npre = 1; end
        if (cond) begin
          if (m_post + 1 == e(cpo)) begin nc = 5; ncl = e(ctr); npre = 0; npost = 0; end
          else npost = m_post + 1;
        end else npost = 0;
      end else begin
        if (m_cl == 1) nc = 0;
      end
      if (m_d == 0) begin
        ndl = m_dl;
        if (m_pend && m_pre) begin nd = 1; ndl = e(lp); nact = ln; end
      end else if (m_d == 1) begin
        if (m_dl == 1) begin nd = 2; ndl = e(dp); end
      end else if (m_d == 2) begin
        if (m_dl == 1) begin nd = 3; ndl = DZ; end
      end else if (m_d == 3) begin
        if (m_dl == 1) nd = 4;
      end else if (m_d == 4) begin
        ndl = m_dl;
        if (m_endp || be) begin nd = 5; ndl = e(dt); end
      end else begin
        if (m_dl == 1) nd = 0;
      end
      if (m_d == 4) nendp = 0;
      else if (be && m_d >= 1 && m_d <= 3) nendp = 1;
      if (bs && en) npend = 1;
      else if (m_d == 0 && m_pre) npend = 0;
      m_c = nc; m_cl = ncl; m_pl = npl; m_post = npost; m_pre = npre;
      m_d = nd; m_dl = ndl; m_act = nact; m_pend = npend; m_endp = nendp;
    end
  end

  // Per-cycle comparison plus directed interval monitors
  bit chk_pre_en = 0, chk_post_en = 0;
  int t_hs = 0, post_seen = 0, lp00_cnt = 0, ready_cnt = 0;
  int prev_c = 0, prev_d0 = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
    if (rst_n) begin
      int d0;
      d0 = int'(dat_st[2:0]);
      chk("R2 clock state", int'(clk_st), m_c);
      for (int i = 0; i < NL; i++)
        chk((i <= m_act) ? "R4 data state" : "R7 idle lane",
            int'(dat_st[i*3 +: 3]), (i <= m_act) ? m_d : 0);
      chk("R10 hs_ready", int'(ready), int'(m_d == 4 && !m_endp));
      if (ready) ready_cnt++;
      if (clk_st == 3'd4 && prev_c != 4) t_hs = cyc;
      if (chk_pre_en && d0 == 1 && prev_d0 == 0)
        chk("R3 pre gap", cyc - t_hs, e(int'((clkt_w >> 16) & 255)) + 1);
      if (d0 == 2) lp00_cnt++;
      if (d0 == 3 && prev_d0 == 2) begin
        chk("R11 R8 data prepare", lp00_cnt, e(int'((data_w >> 16) & 255)));
        lp00_cnt = 0;
      end
      if (d0 != 0) post_seen = 0;
      else if (clk_st == 3'd4) post_seen++;
      if (chk_post_en && clk_st == 3'd5 && prev_c == 4)
        chk("R5 post wait", post_seen, e(int'(clkt_w >> 24)));
      prev_c = int'(clk_st); prev_d0 = d0;
    end
  end

  task automatic pulse_start();
    @(negedge clk); bs = 1'b1; @(negedge clk); bs = 1'b0;
  endtask
  task automatic pulse_end();
    @(negedge clk); be = 1'b1; @(negedge clk); be = 1'b0;
  endtask
  task automatic wait_ready();
    @(negedge clk); while (!ready) @(negedge clk);
  endtask
  task automatic wait_idle();
    @(negedge clk); while (clk_st != 3'd0 || dat_st != '0) @(negedge clk);
  endtask
  task automatic set_ctrl(input bit en, input int lanes_m1);
    ctrl_w = {26'd0, 2'(lanes_m1), 3'd0, en};
  endtask
  task automatic defaults();
    data_w = {8'd10, 8'd6, 8'd0, 8'd14};
    clkt_w = {8'd10, 8'd3, 8'd50, 8'd7};
    trail_w = 32'd30;
  endtask

  initial begin
    defaults();
    set_ctrl(1'b1, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clock", int'(clk_st), 0);
    chk("R1 reset lanes", int'(dat_st), 0);
    chk("R1 reset ready", int'(ready), 0);

    // Default fields, four lanes
    chk_pre_en = 1; chk_post_en = 1;
    pulse_start(); wait_ready(); repeat (5) @(negedge clk); pulse_end(); wait_idle();

    // All-zero fields behave as one, two lanes
    set_ctrl(1'b1, 1);
    data_w = 32'd0; clkt_w = 32'd0; trail_w = 32'd0;
    pulse_start(); wait_ready(); pulse_end(); wait_idle();

    // Enable low drops the request
    chk_pre_en = 0;
    defaults(); set_ctrl(1'b0, 3);
    pulse_start();
    repeat (30) @(negedge clk);
    chk("R9 clock idle while disabled", int'(clk_st), 0);
    set_ctrl(1'b1, 3);
    repeat (30) @(negedge clk);
    chk("R9 dropped start", int'(clk_st), 0);
    chk("R9 lanes idle", int'(dat_st), 0);

    // End request during LP-00, one lane
    set_ctrl(1'b1, 0);
    data_w = {8'd4, 8'd5, 8'd0, 8'd3};
    clkt_w = {8'd6, 8'd2, 8'd4, 8'd3};
    trail_w = 32'd5;
    ready_cnt = 0;
    pulse_start();
    @(negedge clk); while (dat_st[2:0] != 3'd2) @(negedge clk);
    pulse_end(); wait_idle();
    chk("R12 no ready after early end", ready_cnt, 0);

    // New start during the clock-post wait
    chk_post_en = 1;
    set_ctrl(1'b1, 2);
    clkt_w = {8'd20, 8'd2, 8'd4, 8'd3};
    pulse_start(); wait_ready(); pulse_end();
    @(negedge clk); while (!(dat_st[2:0] == 3'd0 && clk_st == 3'd4)) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_start(); wait_ready(); repeat (2) @(negedge clk); pulse_end(); wait_idle();

    // Continuous clock
    chk_post_en = 0;
    set_ctrl(1'b1, 3); cont = 1'b1;
    @(negedge clk); while (clk_st != 3'd4) @(negedge clk);
    pulse_start(); wait_ready(); pulse_end();
    repeat (60) @(negedge clk);
    chk("R6 clock held between bursts", int'(clk_st), 4);
    pulse_start(); wait_ready(); pulse_end();
    repeat (30) @(negedge clk);
    cont = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule